// File: doc/BRIEF.md
# Double-Data-Rate Multi-Lane Word Deserializer

This block turns the serial outputs of an eight-channel converter into parallel 12-bit sample words. Every lane, the eight data lanes and one frame lane alike, is sampled on both edges of a shared bit clock by input cells outside the block. Each bit-clock cycle, those cells deliver one rising-edge bit and one falling-edge bit per lane. The block keeps a short bit history per lane. It finds each word boundary from the 0-to-1 step on the sampled frame lane, and that step may land on either half of a bit pair. It then cuts one word out of every data lane at the same place.

The frame lane also acts as a health monitor. Once four frames in a row show the expected framing, a lock flag rises. From then on, each frame produces one single-cycle valid pulse that presents all eight words together. A malformed frame, or a frame lane that stops toggling, drops the lock at once and stops the pulses until four good frames have been seen again.

The output stream has a valid strobe but no ready input. The converter cannot be paused, so there is no back-pressure. A consumer must take each word set in the cycle its pulse is high. The words stay unchanged on the output until the next pulse.

Top module: `ddr_frame_deserializer`

## Requirements
- R1: Serial bits on every lane are most significant first. Within one cycle's pair, the `*_rise` bit comes before the `*_fall` bit. A word is the 12 serial bits just before a 0-to-1 step of the frame lane. Lane k's word is placed at `word_data[12*k+11 : 12*k]`.
- R2: The frame step is found whether its first 1 is the rising sample (the previous falling sample being 0) or the falling sample (the rising sample of the same cycle being 0). The word window then shifts by one bit to match.
- R3: `word_valid` is high for exactly one cycle per accepted frame. It is registered: it is seen in the cycle right after the one whose input pair contains the step that closes that frame.
- R4: A frame is good when the frame lane's 12 bits, taken over the same window as the word, are six 1s followed by six 0s. `frame_lock` rises with, and `word_valid` first pulses for, the fourth consecutive good frame.
- R5: A frame that is not good clears `frame_lock` in the next cycle, gives no `word_valid` pulse, and restarts the count of good frames from zero.
- R6: `word_valid` is never high while `frame_lock` is low.
- R7: If the frame lane shows no 0-to-1 step for six bit-clock cycles in a row, `frame_lock` clears and the good-frame count restarts.
- R8: A synchronous active-high `rst` clears the bit histories, `frame_lock`, `word_valid` and `word_data`.
- R9: `word_data` changes only in a cycle where `word_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock (one bit pair per lane per cycle) |
| rst | input | 1 | Synchronous reset, active high |
| lane_rise | input | 8 | Rising-edge sample of each data lane |
| lane_fall | input | 8 | Falling-edge sample of each data lane |
| frm_rise | input | 1 | Rising-edge sample of the frame lane |
| frm_fall | input | 1 | Falling-edge sample of the frame lane |
| word_valid | output | 1 | One-cycle pulse: all eight words are new |
| word_data | output | 96 | Eight 12-bit words, lane 0 in the low bits |
| frame_lock | output | 1 | Framing has been stable for four frames |

## Verification
The bench builds the block with its defaults: eight lanes, 12-bit words and a lock threshold of four. This keeps the word width and frame length equal to the stream the bench generates bit by bit. The bench sweeps the stream start over four bit offsets, two landing on a rising sample and two on a falling one. It runs each offset once with clean framing and once with one stretched frame. This covers both window phases, the lock threshold, recovery after a bad frame, and the stall timeout at the end of every stream.

// File: rtl/ddrdes_pkg.sv
`timescale 1ns/1ps
package ddrdes_pkg;

  // Which half of the bit pair carried the first 1 of the frame step.
  typedef enum logic {
    PH_RISE = 1'b0,
    PH_FALL = 1'b1
  } start_phase_e;

  // Bit history kept per lane: one word plus the two bits of the newest pair.
  function automatic int unsigned hist_width(int unsigned word_w);
    return word_w + 2;
  endfunction

endpackage

// File: rtl/ddrdes_lane_hist.sv
`timescale 1ns/1ps
module ddrdes_lane_hist #(
  parameter int unsigned HW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_r,
  input  logic          bit_f,
  output logic [HW-1:0] hist_nx
);

  // Only the older bits need storage; the newest pair arrives each cycle.
  logic [HW-3:0] hist_q;

  // Oldest bit in the MSB; rising sample precedes falling sample.
  assign hist_nx = {hist_q, bit_r, bit_f};

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= hist_nx[HW-3:0];
  end

endmodule

// File: rtl/ddrdes_word_pick.sv
`timescale 1ns/1ps
module ddrdes_word_pick
  import ddrdes_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic [WORD_W+1:0] hist_nx,
  input  start_phase_e      phase,
  output logic [WORD_W-1:0] word
);

  // The newest falling bit always belongs to the next word.
  logic unused_newest;
  assign unused_newest = hist_nx[0];

  always_comb begin
    if (phase == PH_RISE) word = hist_nx[WORD_W+1:2];
    else                  word = hist_nx[WORD_W:1];
  end

endmodule

// File: rtl/ddrdes_frame_align.sv
`timescale 1ns/1ps
module ddrdes_frame_align
  import ddrdes_pkg::*;
#(
  parameter int unsigned WORD_W      = 12,
  parameter int unsigned LOCK_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W+1:0] fhist_nx,
  output logic              take,
  output start_phase_e      phase,
  output logic              locked
);

  localparam int unsigned HALF  = WORD_W / 2;
  localparam int unsigned PAIRS = WORD_W / 2;
  localparam int unsigned CW    = $clog2(LOCK_FRAMES + 1);
  localparam int unsigned TW    = $clog2(PAIRS + 1);
  localparam logic [WORD_W-1:0] PATTERN = {{HALF{1'b1}}, {HALF{1'b0}}};

  logic              step_r, step_f, seen, good, starve, lock_nx;
  logic [WORD_W-1:0] fwin;
  logic [CW-1:0]     cnt_q, cnt_nx;
  logic [TW-1:0]     gap_q;

  // Step on the rising sample: previous falling 0, this rising 1.
  assign step_r = fhist_nx[1] & ~fhist_nx[2];
  // Step on the falling sample: this rising 0, this falling 1.
  assign step_f = fhist_nx[0] & ~fhist_nx[1];
  assign seen   = step_r | step_f;
  assign phase  = step_r ? PH_RISE : PH_FALL;
  assign fwin   = step_r ? fhist_nx[WORD_W+1:2] : fhist_nx[WORD_W:1];
  assign good   = seen && (fwin == PATTERN);
  assign starve = !seen && (gap_q == TW'(PAIRS - 1));

  always_comb begin
    cnt_nx = cnt_q;
    if (seen) begin
      if (!good)                            cnt_nx = '0;
      else if (cnt_q != CW'(LOCK_FRAMES))   cnt_nx = cnt_q + 1'b1;
    end else if (starve) begin
      cnt_nx = '0;
    end
  end

  assign lock_nx = (cnt_nx == CW'(LOCK_FRAMES));
  assign take    = good && lock_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      gap_q  <= '0;
      locked <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      gap_q  <= (seen || starve) ? '0 : gap_q + 1'b1;
      locked <= lock_nx;
    end
  end

  AST_BAD_FRAME_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    (seen && !good) |=> !locked); // R5
  AST_STALL_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    starve |=> !locked); // R7
  AST_LOCK_FROM_GOOD: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(good)); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(LOCK_FRAMES)); // R4

endmodule

// File: rtl/ddr_frame_deserializer.sv
`timescale 1ns/1ps
module ddr_frame_deserializer
  import ddrdes_pkg::*;
#(
  parameter int unsigned LANES       = 8,
  parameter int unsigned WORD_W      = 12,
  parameter int unsigned LOCK_FRAMES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES-1:0]         lane_rise,
  input  logic [LANES-1:0]         lane_fall,
  input  logic                     frm_rise,
  input  logic                     frm_fall,
  output logic                     word_valid,
  output logic [LANES*WORD_W-1:0]  word_data,
  output logic                     frame_lock
);

  localparam int unsigned HW = hist_width(WORD_W);

  logic [HW-1:0]           fhist_nx;
  logic [LANES*WORD_W-1:0] words;
  logic                    take;
  start_phase_e            phase;

  ddrdes_lane_hist #(.HW(HW)) u_frame_hist (
    .clk     (clk),
    .rst     (rst),
    .bit_r   (frm_rise),
    .bit_f   (frm_fall),
    .hist_nx (fhist_nx)
  );

  ddrdes_frame_align #(.WORD_W(WORD_W), .LOCK_FRAMES(LOCK_FRAMES)) u_align (
    .clk      (clk),
    .rst      (rst),
    .fhist_nx (fhist_nx),
    .take     (take),
    .phase    (phase),
    .locked   (frame_lock)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [HW-1:0] hist_nx;

    ddrdes_lane_hist #(.HW(HW)) u_hist (
      .clk     (clk),
      .rst     (rst),
      .bit_r   (lane_rise[g]),
      .bit_f   (lane_fall[g]),
      .hist_nx (hist_nx)
    );

    ddrdes_word_pick #(.WORD_W(WORD_W)) u_pick (
      .hist_nx (hist_nx),
      .phase   (phase),
      .word    (words[g*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= take;
      if (take) word_data <= words;
    end
  end

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> frame_lock); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> $stable(word_data)); // R9
  AST_LOCK_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_lock) |-> word_valid); // R4

endmodule

// File: tb/ddr_frame_deserializer_tb.sv
`timescale 1ns/1ps
module ddr_frame_deserializer_tb;

  localparam int LANES = 8;
  localparam int WW    = 12;
  localparam int NW    = 12;
  localparam int DW    = LANES * WW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LANES-1:0] lane_rise = '0;
  logic [LANES-1:0] lane_fall = '0;
  logic             frm_rise = 1'b0;
  logic             frm_fall = 1'b0;
  logic             word_valid;
  logic [DW-1:0]    word_data;
  logic             frame_lock;

  int n_cmp = 0;
  int n_bad = 0;
  int off   = 0;
  int badj  = -100;

  always #10 clk = ~clk;

  ddr_frame_deserializer u_dut (
    .clk        (clk),
    .rst        (rst),
    .lane_rise  (lane_rise),
    .lane_fall  (lane_fall),
    .frm_rise   (frm_rise),
    .frm_fall   (frm_fall),
    .word_valid (word_valid),
    .word_data  (word_data),
    .frame_lock (frame_lock)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] word_val(int w, int l);
    if (w == 5) return (l % 2 == 0) ? 12'hFFF : 12'h000;
    return 12'((w * 611 + l * 173 + off * 29 + 'h5A3) & 'hFFF);
  endfunction

  function automatic logic frame_bit(int n);
    int q, p;
    if (n < off) return 1'b0;
    q = (n - off) / WW;
    p = (n - off) % WW;
    if (q >= NW) return 1'b0;
    if (q == badj && p == WW / 2) return 1'b1;
    return (p < WW / 2);
  endfunction

  function automatic logic data_bit(int n, int l);
    int q, p;
    logic [WW-1:0] v;
    if (n < off) return 1'b0;
    q = (n - off) / WW;
    p = (n - off) % WW;
    if (q >= NW) return 1'b0;
    v = word_val(q, l);
    return v[WW-1-p];
  endfunction

  function automatic bit exp_valid(int w);
    if (w < 3) return 1'b0;
    for (int k = w - 3; k <= w; k++) if (k == badj) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run(input int o, input int bj);
    logic [DW-1:0] last, expw;
    int T, jw;
    bit has, ev;
    off  = o;
    badj = bj;
    rst = 1'b1;
    lane_rise = '0; lane_fall = '0; frm_rise = 1'b0; frm_fall = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check(!word_valid && !frame_lock && word_data == '0, "R8 reset state",
          {word_data, word_valid, frame_lock}, '0);
    rst  = 1'b0;
    last = '0;
    T = (off + WW * NW) / 2 + 20;
    for (int c = 0; c < T; c++) begin
      frm_rise = frame_bit(2 * c);
      frm_fall = frame_bit(2 * c + 1);
      for (int l = 0; l < LANES; l++) begin
        lane_rise[l] = data_bit(2 * c, l);
        lane_fall[l] = data_bit(2 * c + 1, l);
      end
      @(posedge clk);
      #5;
      has = 1'b0;
      jw  = 0;
      for (int w = -1; w <= NW - 2; w++)
        if ((off + WW * (w + 1)) / 2 == c) begin has = 1'b1; jw = w; end
      ev = has && exp_valid(jw);
      check(word_valid == ev, "R3 R6 valid timing", DW'(word_valid), DW'(ev));
      if (has)
        check(frame_lock == ev, "R4 R5 lock at frame close", DW'(frame_lock), DW'(ev));
      if (ev) begin
        for (int l = 0; l < LANES; l++) expw[l*WW +: WW] = word_val(jw, l);
        check(word_data == expw, (off % 2 == 0) ? "R1 R2 word rise phase" : "R1 R2 word fall phase",
              word_data, expw);
        last = expw;
      end else begin
        check(word_data == last, "R9 data hold", word_data, last);
      end
    end
    check(!frame_lock, "R7 lock after stalled frame lane", DW'(frame_lock), '0);
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int o = 0; o < 4; o++) begin
      run(o, -100);
      run(o, 4);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule